// File: doc/BRIEF.md
# Signature-Tagged Compressed Cache Lookup

This block is the lookup path of a cache whose physical lines each carry several compressed blocks. Those blocks may come from unrelated addresses, and no tag storage is added to hold them. Each set owns one 64-byte line split into four 16-byte slots. The tag array keeps only a short signature per slot, and the full tag of each block sits inside its slot next to the compressed payload. A lookup first compares signatures. It touches the data array only when a signature agrees, and then confirms the hit against the embedded full tag. When the full tag disagrees, the result is flagged as a false positive and handled as a miss.

A line can also be turned into a superblock line, which holds neighbouring blocks of one aligned group of four tags. A reserved signature code in slot zero marks such a line. In that mode a block's position follows from its low tag bits. The fill port installs blocks. An ordinary fill goes to the lowest free slot, or to the least recently used slot when the set is full.

Top module: `scc_lookup`

## Requirements
- R1: The signature of a 24-bit tag is the XOR of its three bytes. If that XOR is 0xFF, the signature becomes 0xFE, so 0xFF never appears as an ordinary signature.
- R2: After reset every slot is invalid. Every lookup misses with the false-positive flag low and without reading the data array.
- R3: When no valid slot signature matches the request, the data array is not read (data_rd stays low). A miss is reported with resp_fp low, in the second cycle after the request edge.
- R4: When a matching slot's embedded tag equals the request tag, the block reports a hit. The response carries that slot's index on resp_slot and its payload on resp_data, in the second cycle after the request edge.
- R5: When a signature matches but the embedded tag differs, the block reports a miss with resp_fp high.
- R6: With several matching slots, the lowest-numbered one is verified first. After a false positive, the next one is verified one cycle later. A hit found there responds in the third cycle after the request edge, with resp_fp high.
- R7: resp_valid is high for exactly one cycle per lookup, and exactly one of resp_hit and resp_miss is high with it. resp_hit, resp_miss and resp_fp are low whenever resp_valid is low.
- R8: An ordinary fill into a line that is not in superblock mode goes to the lowest-numbered invalid slot.
- R9: An ordinary fill into a full set replaces the least recently used slot. Both hits and fills count as uses.
- R10: A fill with fill_super high marks the line by writing 0xFF into slot 0's signature. It places the block in the slot given by tag bits [1:0]. A block that shares a line with others of its aligned group of four leaves them intact, and each can then be hit at that slot.
- R11: An ordinary fill into a superblock line clears the line and puts the new block in slot 0. The earlier blocks then miss.
- R12: req_ready is low while a lookup is in flight and while fill_valid is high, so a fill wins over a request in the same cycle. fill_ready is low only while a lookup is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Lookup byte address (tag 31:8, set 7:4) |
| req_ready | output | 1 | Request accepted on this edge when high |
| fill_valid | input | 1 | Install request |
| fill_addr | input | 32 | Address of the block being installed |
| fill_super | input | 1 | Install as a member of a superblock line |
| fill_data | input | 104 | Compressed payload of the block |
| fill_ready | output | 1 | Fill accepted on this edge when high |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Confirmed hit |
| resp_miss | output | 1 | Miss, including rejected false positives |
| resp_fp | output | 1 | At least one signature match failed the full-tag check |
| resp_slot | output | 2 | Slot index of the hit |
| resp_data | output | 104 | Payload of the hit |
| data_rd | output | 1 | Data array accessed in this cycle |

## Verification
On every cycle the checker enforces that responses are single-cycle pulses with exactly one outcome bit. It also checks that a plain miss was preceded by no data access, that any hit or false positive was preceded by one, and that no data access overlaps an idle request or fill port. Signature folding, slot placement, LRU victim choice, superblock marking and clearing, and the extra cycle of the two-candidate walk all depend on which tags were installed earlier. Only the bench's directed scenarios can show these, using tags chosen to collide on purpose.

// File: rtl/scc_pkg.sv
package scc_pkg;

    parameter int ADDR_W     = 32;
    parameter int OFF_W      = 4;
    parameter int SET_W      = 4;
    parameter int SLOTS      = 4;
    parameter int SIG_W      = 8;
    parameter int LINE_BYTES = 64;

    localparam int TAG_W      = ADDR_W - OFF_W - SET_W;
    localparam int SLOT_W     = LINE_BYTES * 8 / SLOTS;
    localparam int PAY_W      = SLOT_W - TAG_W;
    localparam int NSETS      = 1 << SET_W;
    localparam int SLOT_IDX_W = $clog2(SLOTS);
    localparam int FOLDS      = (TAG_W + SIG_W - 1) / SIG_W;

    typedef logic [TAG_W-1:0]      tag_t;
    typedef logic [SIG_W-1:0]      sig_t;
    typedef logic [SET_W-1:0]      set_t;
    typedef logic [SLOT_IDX_W-1:0] slot_idx_t;
    typedef logic [PAY_W-1:0]      pay_t;

    localparam sig_t SIG_MARK = '1;

    typedef struct packed {
        sig_t [SLOTS-1:0] sig;
        logic [SLOTS-1:0] vld;
    } tag_entry_t;

    typedef struct packed {
        tag_t tag;
        pay_t pay;
    } slot_t;

    typedef enum logic {ST_IDLE, ST_CHECK} state_e;

    function automatic sig_t sig_fold(tag_t t);
        sig_t acc;
        acc = '0;
        for (int i = 0; i < FOLDS; i++) begin
            for (int b = 0; b < SIG_W; b++) begin
                if (i * SIG_W + b < TAG_W) acc[b] = acc[b] ^ t[i*SIG_W+b];
            end
        end
        if (acc == SIG_MARK) acc = SIG_MARK - sig_t'(1);
        return acc;
    endfunction

    function automatic tag_t group_base(tag_t t);
        tag_t r;
        r = t;
        r[SLOT_IDX_W-1:0] = '0;
        return r;
    endfunction

    function automatic slot_idx_t lowest_set(logic [SLOTS-1:0] m);
        slot_idx_t r;
        r = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (m[i]) r = slot_idx_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/scc_sig_match.sv
module scc_sig_match
    import scc_pkg::*;
(
    input  tag_entry_t       ent,
    input  tag_t             tag,
    output logic [SLOTS-1:0] mask
);
    sig_t             rsig;
    sig_t             gsig;
    slot_idx_t        pos;
    logic             grouped;
    logic [SLOTS-1:0] plain;

    assign rsig    = sig_fold(tag);
    assign gsig    = sig_fold(group_base(tag));
    assign pos     = tag[SLOT_IDX_W-1:0];
    assign grouped = (ent.sig[0] == SIG_MARK);

    for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
        assign plain[i] = ent.vld[i] && (ent.sig[i] == rsig);
    end

    always_comb begin
        if (grouped) begin
            mask = '0;
            if (ent.sig[1] == gsig && ent.vld[pos]) mask[pos] = 1'b1;
        end else begin
            mask = plain;
        end
    end
endmodule

// File: rtl/scc_lru.sv
module scc_lru
    import scc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      touch_en,
    input  set_t      touch_set,
    input  slot_idx_t touch_slot,
    input  set_t      q_set,
    output slot_idx_t victim
);
    slot_idx_t age [NSETS][SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++) begin
                for (int i = 0; i < SLOTS; i++) age[s][i] <= slot_idx_t'(i);
            end
        end else if (touch_en) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (slot_idx_t'(i) == touch_slot)
                    age[touch_set][i] <= '0;
                else if (age[touch_set][i] < age[touch_set][touch_slot])
                    age[touch_set][i] <= age[touch_set][i] + slot_idx_t'(1);
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (age[q_set][i] == slot_idx_t'(SLOTS - 1)) victim = slot_idx_t'(i);
        end
    end
endmodule

// File: rtl/scc_data_store.sv
module scc_data_store
    import scc_pkg::*;
(
    input  logic      clk,
    input  logic      we,
    input  set_t      wset,
    input  slot_idx_t wslot,
    input  slot_t     wdata,
    input  set_t      rset,
    input  slot_idx_t rslot,
    output slot_t     rdata
);
    localparam int DEPTH = NSETS * SLOTS;

    slot_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[{wset, wslot}] <= wdata;
    end

    assign rdata = mem[{rset, rslot}];
endmodule

// File: rtl/scc_lookup.sv
module scc_lookup
    import scc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_super,
    input  logic [PAY_W-1:0]  fill_data,
    output logic              fill_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_miss,
    output logic              resp_fp,
    output logic [SLOT_IDX_W-1:0] resp_slot,
    output logic [PAY_W-1:0]  resp_data,
    output logic              data_rd
);
    tag_entry_t tags [NSETS];

    state_e           state;
    set_t             s_set;
    tag_t             s_tag;
    logic [SLOTS-1:0] s_mask;
    logic             s_fp;

    tag_t             req_tag, fill_tag;
    set_t             req_set, fill_set;
    logic [SLOTS-1:0] req_mask;
    logic             req_go, fill_go;

    logic             unused_offsets;
    assign unused_offsets = ^{req_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign req_set  = req_addr[OFF_W +: SET_W];
    assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
    assign fill_set = fill_addr[OFF_W +: SET_W];

    assign fill_ready = (state == ST_IDLE);
    assign req_ready  = (state == ST_IDLE) && !fill_valid;
    assign fill_go    = fill_valid && fill_ready;
    assign req_go     = req_valid && req_ready;

    scc_sig_match u_match (
        .ent  (tags[req_set]),
        .tag  (req_tag),
        .mask (req_mask)
    );

    // Candidate walk: lowest remaining match is verified against its full tag
    slot_idx_t        cand;
    logic             any_cand;
    logic [SLOTS-1:0] rest_mask;
    slot_t            rd_slot;
    logic             tag_eq;

    assign cand     = lowest_set(s_mask);
    assign any_cand = |s_mask;
    assign data_rd  = (state == ST_CHECK) && any_cand;
    assign tag_eq   = (rd_slot.tag == s_tag);

    always_comb begin
        rest_mask       = s_mask;
        rest_mask[cand] = 1'b0;
    end

    // Fill placement
    slot_idx_t  victim;
    slot_idx_t  f_slot;
    tag_entry_t f_ent;
    tag_entry_t cur_ent;
    sig_t       f_sig, f_gsig;

    assign cur_ent = tags[fill_set];
    assign f_sig   = sig_fold(fill_tag);
    assign f_gsig  = sig_fold(group_base(fill_tag));

    always_comb begin
        f_ent  = cur_ent;
        f_slot = '0;
        if (fill_super) begin
            f_slot = fill_tag[SLOT_IDX_W-1:0];
            if (!(cur_ent.sig[0] == SIG_MARK && cur_ent.sig[1] == f_gsig)) begin
                f_ent.sig    = '0;
                f_ent.vld    = '0;
                f_ent.sig[0] = SIG_MARK;
                f_ent.sig[1] = f_gsig;
            end
            f_ent.vld[f_slot] = 1'b1;
        end else if (cur_ent.sig[0] == SIG_MARK) begin
            f_ent.sig    = '0;
            f_ent.vld    = '0;
            f_ent.sig[0] = f_sig;
            f_ent.vld[0] = 1'b1;
        end else begin
            if (&cur_ent.vld) f_slot = victim;
            else              f_slot = lowest_set(~cur_ent.vld);
            f_ent.sig[f_slot] = f_sig;
            f_ent.vld[f_slot] = 1'b1;
        end
    end

    // Recency tracking: hits during check, fills while idle
    logic      hit_now;
    logic      touch_en;
    set_t      touch_set;
    slot_idx_t touch_slot;

    assign hit_now    = data_rd && tag_eq;
    assign touch_en   = hit_now || fill_go;
    assign touch_set  = hit_now ? s_set : fill_set;
    assign touch_slot = hit_now ? cand  : f_slot;

    scc_lru u_lru (
        .clk        (clk),
        .rst        (rst),
        .touch_en   (touch_en),
        .touch_set  (touch_set),
        .touch_slot (touch_slot),
        .q_set      (fill_set),
        .victim     (victim)
    );

    slot_t wdata;
    assign wdata = '{tag: fill_tag, pay: fill_data};

    scc_data_store u_store (
        .clk   (clk),
        .we    (fill_go),
        .wset  (fill_set),
        .wslot (f_slot),
        .wdata (wdata),
        .rset  (s_set),
        .rslot (cand),
        .rdata (rd_slot)
    );

    // Tag array
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++) tags[s] <= '0;
        end else if (fill_go) begin
            tags[fill_set] <= f_ent;
        end
    end

    // Lookup sequencer and response
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            s_set      <= '0;
            s_tag      <= '0;
            s_mask     <= '0;
            s_fp       <= 1'b0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_miss  <= 1'b0;
            resp_fp    <= 1'b0;
            resp_slot  <= '0;
            resp_data  <= '0;
        end else begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_miss  <= 1'b0;
            resp_fp    <= 1'b0;
            resp_slot  <= '0;
            resp_data  <= '0;
            case (state)
                ST_IDLE: begin
                    if (req_go) begin
                        s_set  <= req_set;
                        s_tag  <= req_tag;
                        s_mask <= req_mask;
                        s_fp   <= 1'b0;
                        state  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!any_cand) begin
                        resp_valid <= 1'b1;
                        resp_miss  <= 1'b1;
                        resp_fp    <= s_fp;
                        state      <= ST_IDLE;
                    end else if (tag_eq) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b1;
                        resp_fp    <= s_fp;
                        resp_slot  <= cand;
                        resp_data  <= rd_slot.pay;
                        s_mask     <= '0;
                        state      <= ST_IDLE;
                    end else begin
                        s_mask <= rest_mask;
                        s_fp   <= 1'b1;
                        if (rest_mask == '0) begin
                            resp_valid <= 1'b1;
                            resp_miss  <= 1'b1;
                            resp_fp    <= 1'b1;
                            state      <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scc_lookup_chk.sv
module scc_lookup_chk (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic fill_ready,
    input logic resp_valid,
    input logic resp_hit,
    input logic resp_miss,
    input logic resp_fp,
    input logic data_rd
);
    assert_resp_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    assert_resp_one_outcome_R7: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $countones({resp_hit, resp_miss}) == 1);

    assert_resp_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> !(resp_hit || resp_miss || resp_fp));

    assert_plain_miss_noread_R3: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_miss && !resp_fp) |-> $past(!data_rd));

    assert_hit_after_read_R4: assert property (@(posedge clk) disable iff (rst)
        resp_hit |-> $past(data_rd));

    assert_fp_after_read_R5: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fp) |-> $past(data_rd));

    assert_busy_ports_R12: assert property (@(posedge clk) disable iff (rst)
        data_rd |-> (!req_ready && !fill_ready));
endmodule

bind scc_lookup scc_lookup_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .fill_ready (fill_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_miss  (resp_miss),
    .resp_fp    (resp_fp),
    .data_rd    (data_rd)
);

// File: tb/scc_lookup_bench.sv
module scc_lookup_bench;
    localparam int PAYW = 104;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic [31:0]     req_addr = '0;
    logic            req_ready;
    logic            fill_valid = 1'b0;
    logic [31:0]     fill_addr = '0;
    logic            fill_super = 1'b0;
    logic [PAYW-1:0] fill_data = '0;
    logic            fill_ready;
    logic            resp_valid, resp_hit, resp_miss, resp_fp;
    logic [1:0]      resp_slot;
    logic [PAYW-1:0] resp_data;
    logic            data_rd;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    scc_lookup u_scc_lookup (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_super(fill_super),
        .fill_data(fill_data), .fill_ready(fill_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
        .resp_fp(resp_fp), .resp_slot(resp_slot), .resp_data(resp_data),
        .data_rd(data_rd)
    );

    function automatic logic [31:0] mk(logic [23:0] tag, logic [3:0] set);
        return {tag, set, 4'h0};
    endfunction

    function automatic logic [PAYW-1:0] pay(logic [23:0] tag);
        return {4{tag, 2'b10}};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_fill(logic [23:0] tag, logic [3:0] set, bit sup);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = mk(tag, set);
        fill_super = sup;
        fill_data  = pay(tag);
        @(negedge clk);
        fill_valid = 1'b0;
        fill_super = 1'b0;
    endtask

    // Issues one lookup and checks outcome, fp flag, latency, data reads, slot and payload
    task automatic look(string req, logic [23:0] tag, logic [3:0] set, bit exp_hit,
                        bit exp_fp, int exp_lat, int exp_reads, logic [1:0] exp_slot);
        int lat = 0;
        int reads = 0;
        bit h = 0, m = 0, f = 0;
        logic [1:0] s = '0;
        logic [PAYW-1:0] d = '0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = mk(tag, set);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R12", "req_ready while busy", req_ready, 0);
        for (int k = 1; k <= 8; k++) begin
            if (data_rd) reads++;
            if (resp_valid) begin
                lat = k; h = resp_hit; m = resp_miss; f = resp_fp; s = resp_slot; d = resp_data;
                break;
            end
            @(negedge clk);
        end
        chk(h == exp_hit && m == !exp_hit, req, "hit", h, exp_hit);
        chk(f == exp_fp, req, "fp flag", f, exp_fp);
        chk(lat == exp_lat, req, "latency", lat, exp_lat);
        chk(reads == exp_reads, req, "data reads", reads, exp_reads);
        if (exp_hit) begin
            chk(s == exp_slot, req, "slot", s, exp_slot);
            chk(d == pay(tag), req, "payload", d, pay(tag));
        end
        @(negedge clk);
        chk(resp_valid == 1'b0, "R7", "response width", resp_valid, 0);
    endtask

    task automatic test_reset();
        chk(req_ready && fill_ready && !resp_valid, "R2", "idle after reset",
            {req_ready, fill_ready, resp_valid}, 3'b110);
        look("R2", 24'h000000, 4'h0, 0, 0, 2, 0, 0);
        look("R2", 24'hABCDEF, 4'hF, 0, 0, 2, 0, 0);
    endtask

    task automatic test_hit_and_fp();
        do_fill(24'h001200, 4'h2, 0);
        look("R4", 24'h001200, 4'h2, 1, 0, 2, 1, 0);
        look("R5", 24'h000012, 4'h2, 0, 1, 2, 1, 0);
        look("R3", 24'h000013, 4'h2, 0, 0, 2, 0, 0);
        do_fill(24'h120000, 4'h2, 0);
        look("R8", 24'h120000, 4'h2, 1, 1, 3, 2, 1);
        look("R6", 24'h120000, 4'h2, 1, 1, 3, 2, 1);
        look("R6", 24'h000012, 4'h2, 0, 1, 3, 2, 0);
    endtask

    task automatic test_fold();
        // 0x12^0x34^0x56 = 0x70 ; 0xFF folds to reserved code and becomes 0xFE
        do_fill(24'h123456, 4'h6, 0);
        look("R1", 24'h000070, 4'h6, 0, 1, 2, 1, 0);
        do_fill(24'h0000FF, 4'h7, 0);
        look("R1", 24'h0000FE, 4'h7, 0, 1, 2, 1, 0);
        look("R1", 24'h0000FF, 4'h7, 1, 0, 2, 1, 0);
    endtask

    task automatic test_lru();
        do_fill(24'h000031, 4'h3, 0);
        do_fill(24'h000032, 4'h3, 0);
        do_fill(24'h000033, 4'h3, 0);
        do_fill(24'h000034, 4'h3, 0);
        look("R8", 24'h000033, 4'h3, 1, 0, 2, 1, 2);
        look("R8", 24'h000034, 4'h3, 1, 0, 2, 1, 3);
        look("R9", 24'h000031, 4'h3, 1, 0, 2, 1, 0);
        do_fill(24'h000035, 4'h3, 0);
        look("R9", 24'h000032, 4'h3, 0, 0, 2, 0, 0);
        look("R9", 24'h000035, 4'h3, 1, 0, 2, 1, 1);
        look("R9", 24'h000031, 4'h3, 1, 0, 2, 1, 0);
    endtask

    task automatic test_super();
        do_fill(24'h000102, 4'h5, 1);
        do_fill(24'h000100, 4'h5, 1);
        look("R10", 24'h000102, 4'h5, 1, 0, 2, 1, 2);
        look("R10", 24'h000100, 4'h5, 1, 0, 2, 1, 0);
        look("R10", 24'h000101, 4'h5, 0, 0, 2, 0, 0);
        do_fill(24'h000777, 4'h5, 0);
        look("R11", 24'h000102, 4'h5, 0, 0, 2, 0, 0);
        look("R11", 24'h000100, 4'h5, 0, 0, 2, 0, 0);
        look("R11", 24'h000777, 4'h5, 1, 0, 2, 1, 0);
    endtask

    task automatic test_priority();
        bit got = 0, h = 0;
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = mk(24'h0ABC01, 4'h9);
        fill_data  = pay(24'h0ABC01);
        req_valid  = 1'b1;
        req_addr   = mk(24'h0ABC01, 4'h9);
        #1;
        chk(req_ready == 1'b0 && fill_ready == 1'b1, "R12", "fill wins",
            {req_ready, fill_ready}, 2'b01);
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R12", "ready after fill", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (resp_valid && !got) begin got = 1; h = resp_hit; end
            @(negedge clk);
        end
        chk(got && h, "R12", "request after fill hits", {got, h}, 2'b11);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_hit_and_fp();
        test_fold();
        test_lru();
        test_super();
        test_priority();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule